// File: doc/BRIEF.md
# Prescaled Reload Down-Counter Timer

A 23-bit down-counting timer with a small word-addressed register interface. Software writes a start value, chooses a prescaler ratio of 1, 16 or 256, and turns counting on. Each prescaler tick lowers the count by one. A tick that arrives while the count is already zero is an underflow. On underflow the timer either reloads the start value and keeps running, or stays at zero and clears its own run bit.

An optional compare register adds a second event source. The event fires on the tick that brings the count to the compare value. Both event sources set one sticky status bit, which software clears by writing the clear address. The interrupt output is either a one-cycle pulse per event or a level that mirrors the status bit.

Top module: `tmr_reload_timer`

## Requirements
- R1: After reset the count reads 0x7FFFFF, the start value and the control word read 0, the compare register reads 0x7FFFFF and irq_o is low.
- R2: Byte offsets are 0x00 start value, 0x04 count, 0x08 control, 0x0C status clear and 0x10 compare. Control bit 0 is the output mode, bits 3:2 are the prescaler code, bit 6 is auto-reload, bit 7 is run and bit 8 is status; the other bits read 0. The count and status bit 8 are read-only, so writes to them change nothing. Read data follows the address with no clock delay.
- R3: A write to 0x00 stores the value and also puts it into the count at the same clock edge. It restarts the prescaler, and it takes priority over a tick in that cycle.
- R4: While run is set, the count falls by one every 1, 16 or 256 clocks for prescaler codes 0, 1 and 2. Code 3 acts as 256. The first decrement comes one full period after run is set.
- R5: A tick while the count is zero sets status. With auto-reload set, the count takes the start value, so the events come every start+1 ticks.
- R6: On an underflow with auto-reload clear, the count stays at zero and control bit 7 is cleared, unless control is written in that same cycle.
- R7: A tick whose new count equals the compare value sets status. If that tick is also an underflow, only one event results.
- R8: Status stays set until a write to 0x0C. If a new event arrives in the same cycle as the clear, status stays set.
- R9: With control bit 0 = 0, irq_o is high for exactly the one cycle after each event edge.
- R10: With control bit 0 = 1, irq_o equals the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | Write strobe, qualified by bus_sel_i |
| bus_addr_i | input | 5 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| irq_o | output | 1 | Interrupt, pulse or level by control bit 0 |

## Verification
Two collisions matter most. The first is a write to the clear address landing in the cycle that an auto-reload underflow occurs. The bench times a clear onto the edge of the second underflow, expects status to survive, and then expects a clear one cycle later to take effect. The second collision comes from setting the compare value equal to the start value. The compare then matches on the underflow tick itself, and in pulse mode the bench expects exactly one pulse, at that edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // register byte offsets
    localparam logic [4:0] OFS_LOAD  = 5'h00;
    localparam logic [4:0] OFS_COUNT = 5'h04;
    localparam logic [4:0] OFS_CTRL  = 5'h08;
    localparam logic [4:0] OFS_ACK   = 5'h0C;
    localparam logic [4:0] OFS_ALARM = 5'h10;

    // control word bit positions
    localparam int B_LVL  = 0;
    localparam int B_DIV  = 2;
    localparam int B_AUTO = 6;
    localparam int B_RUN  = 7;
    localparam int B_STAT = 8;

    typedef struct packed {
        logic       run;
        logic       autoload;
        logic [1:0] div;
        logic       lvl;
    } tmr_ctrl_t;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int unsigned MID_LOG = 4,
    parameter int unsigned MAX_LOG = 8
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       run_i,
    input  logic       restart_i,
    input  logic [1:0] code_i,
    output logic       tick_o
);
    localparam int unsigned W = MAX_LOG;
    localparam logic [W-1:0] LIM_MID = W'((1 << MID_LOG) - 1);
    localparam logic [W-1:0] LIM_MAX = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [W-1:0] limit;

    always_comb begin
        case (code_i)
            2'd0:    limit = '0;
            2'd1:    limit = LIM_MID;
            default: limit = LIM_MAX;
        endcase
        tick_o = run_i && (st_q.cnt == limit);
        st_d   = st_q;
        if (!run_i || restart_i || (st_q.cnt >= limit)) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int unsigned CNT_W     = 23,
    parameter bit          HAS_ALARM = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wr_val_i,
    input  logic [CNT_W-1:0] reload_val_i,
    input  logic             autoload_i,
    input  logic [CNT_W-1:0] alarm_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             uf_o,
    output logic             alm_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CNT_W-1:0] step;

    always_comb begin
        uf_o = tick_i && !wr_i && (st_q.count == '0);
        if (st_q.count == '0) begin
            step = autoload_i ? reload_val_i : '0;
        end else begin
            step = st_q.count - CNT_W'(1);
        end
        st_d = st_q;
        if (wr_i) begin
            st_d.count = wr_val_i;
        end else if (tick_i) begin
            st_d.count = step;
        end
    end

    generate
        if (HAS_ALARM) begin : g_alarm
            assign alm_o = tick_i && !wr_i && (step == alarm_val_i);
        end else begin : g_noalarm
            logic unused_alarm;
            assign unused_alarm = ^alarm_val_i;
            assign alm_o = 1'b0;
        end
    endgenerate

    assign count_o = st_q.count;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.count <= '1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic evt_i,
    input  logic ack_i,
    input  logic lvl_i,
    output logic status_o,
    output logic irq_o
);
    typedef struct packed {
        logic status;
        logic pulse;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = evt_i;
        if (evt_i) begin
            st_d.status = 1'b1;
        end else if (ack_i) begin
            st_d.status = 1'b0;
        end
    end

    assign status_o = st_q.status;
    assign irq_o    = lvl_i ? st_q.status : st_q.pulse;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tmr_reload_timer.sv
module tmr_reload_timer
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W     = 23,
    parameter bit          HAS_ALARM = 1'b1,
    parameter int unsigned MID_LOG   = 4,
    parameter int unsigned MAX_LOG   = 8,
    parameter int unsigned AW        = 5,
    parameter int unsigned DW        = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          bus_sel_i,
    input  logic          bus_we_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [DW-1:0] bus_wdata_i,
    output logic [DW-1:0] bus_rdata_o,
    output logic          irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] load;
        tmr_ctrl_t        ctrl;
        logic [CNT_W-1:0] alarm;
    } regs_t;

    regs_t regs_d, regs_q;

    logic wr_any, wr_load, wr_ctrl, wr_ack, wr_alarm;
    logic tick, uf_evt, alm_evt, evt, status;
    logic [CNT_W-1:0] count;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata_i;
    assign wr_any   = bus_sel_i && bus_we_i;
    assign wr_load  = wr_any && (bus_addr_i == AW'(OFS_LOAD));
    assign wr_ctrl  = wr_any && (bus_addr_i == AW'(OFS_CTRL));
    assign wr_ack   = wr_any && (bus_addr_i == AW'(OFS_ACK));
    assign wr_alarm = wr_any && (bus_addr_i == AW'(OFS_ALARM)) && HAS_ALARM;
    assign evt      = uf_evt || alm_evt;

    always_comb begin
        regs_d = regs_q;
        if (wr_load) begin
            regs_d.load = bus_wdata_i[CNT_W-1:0];
        end
        if (wr_ctrl) begin
            regs_d.ctrl.lvl      = bus_wdata_i[B_LVL];
            regs_d.ctrl.div      = bus_wdata_i[B_DIV+:2];
            regs_d.ctrl.autoload = bus_wdata_i[B_AUTO];
            regs_d.ctrl.run      = bus_wdata_i[B_RUN];
        end else if (uf_evt && !regs_q.ctrl.autoload) begin
            regs_d.ctrl.run = 1'b0;
        end
        if (wr_alarm) begin
            regs_d.alarm = bus_wdata_i[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            regs_q.load  <= '0;
            regs_q.ctrl  <= '0;
            regs_q.alarm <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    tmr_prescale #(
        .MID_LOG (MID_LOG),
        .MAX_LOG (MAX_LOG)
    ) u_pre (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (regs_q.ctrl.run),
        .restart_i (wr_load),
        .code_i    (regs_q.ctrl.div),
        .tick_o    (tick)
    );

    tmr_count #(
        .CNT_W     (CNT_W),
        .HAS_ALARM (HAS_ALARM)
    ) u_cnt (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tick_i       (tick),
        .wr_i         (wr_load),
        .wr_val_i     (bus_wdata_i[CNT_W-1:0]),
        .reload_val_i (regs_q.load),
        .autoload_i   (regs_q.ctrl.autoload),
        .alarm_val_i  (regs_q.alarm),
        .count_o      (count),
        .uf_o         (uf_evt),
        .alm_o        (alm_evt)
    );

    tmr_irq u_irq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .evt_i    (evt),
        .ack_i    (wr_ack),
        .lvl_i    (regs_q.ctrl.lvl),
        .status_o (status),
        .irq_o    (irq_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            AW'(OFS_LOAD):  bus_rdata_o[CNT_W-1:0] = regs_q.load;
            AW'(OFS_COUNT): bus_rdata_o[CNT_W-1:0] = count;
            AW'(OFS_CTRL): begin
                bus_rdata_o[B_LVL]    = regs_q.ctrl.lvl;
                bus_rdata_o[B_DIV+:2] = regs_q.ctrl.div;
                bus_rdata_o[B_AUTO]   = regs_q.ctrl.autoload;
                bus_rdata_o[B_RUN]    = regs_q.ctrl.run;
                bus_rdata_o[B_STAT]   = status;
            end
            AW'(OFS_ALARM): begin
                if (HAS_ALARM) begin
                    bus_rdata_o[CNT_W-1:0] = regs_q.alarm;
                end
            end
            default: ;
        endcase
    end
endmodule

module tmr_reload_timer_chk
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 23,
    parameter int unsigned AW    = 5
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             sel_i,
    input logic             we_i,
    input logic [AW-1:0]    addr_i,
    input logic [CNT_W-1:0] wdata_i,
    input logic             irq_i,
    input logic             evt_i,
    input logic             uf_i,
    input logic             lvl_i,
    input logic             auto_i,
    input logic             run_i,
    input logic             status_i,
    input logic [CNT_W-1:0] count_i
);
    logic c_load, c_ctrl, c_ack;
    assign c_load = sel_i && we_i && (addr_i == AW'(OFS_LOAD));
    assign c_ctrl = sel_i && we_i && (addr_i == AW'(OFS_CTRL));
    assign c_ack  = sel_i && we_i && (addr_i == AW'(OFS_ACK));

    // R3
    load_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        c_load |=> (count_i == $past(wdata_i)));

    // R6
    stop_clears_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (uf_i && !auto_i && !c_ctrl) |=> !run_i);

    // R8
    evt_sets_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_i |=> status_i);

    // R8
    ack_clears_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (c_ack && !evt_i) |=> !status_i);

    // R9
    edge_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!lvl_i && irq_i) |-> $past(evt_i));

    // R10
    level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lvl_i |-> (irq_i == status_i));
endmodule

bind tmr_reload_timer tmr_reload_timer_chk #(
    .CNT_W (CNT_W),
    .AW    (AW)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (bus_sel_i),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i[CNT_W-1:0]),
    .irq_i    (irq_o),
    .evt_i    (evt),
    .uf_i     (uf_evt),
    .lvl_i    (regs_q.ctrl.lvl),
    .auto_i   (regs_q.ctrl.autoload),
    .run_i    (regs_q.ctrl.run),
    .status_i (status),
    .count_i  (count)
);

// File: tb/tmr_reload_timer_bench.sv
module tmr_reload_timer_bench;
    localparam int CLK_NS = 10;

    localparam logic [4:0] A_LOAD  = 5'h00;
    localparam logic [4:0] A_COUNT = 5'h04;
    localparam logic [4:0] A_CTRL  = 5'h08;
    localparam logic [4:0] A_ACK   = 5'h0C;
    localparam logic [4:0] A_ALARM = 5'h10;

    localparam logic [31:0] C_LVL  = 32'h1;
    localparam logic [31:0] C_AUTO = 32'h40;
    localparam logic [31:0] C_RUN  = 32'h80;

    typedef struct packed {
        logic [22:0] load;
        logic [1:0]  div;
        logic        auto;
        logic [15:0] wait_n;
        logic [22:0] exp_count;
        logic        exp_stat;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{load: 23'd5, div: 2'd0, auto: 1'b0, wait_n: 16'd3,   exp_count: 23'd2, exp_stat: 1'b0},
        '{load: 23'd5, div: 2'd0, auto: 1'b0, wait_n: 16'd6,   exp_count: 23'd0, exp_stat: 1'b1},
        '{load: 23'd5, div: 2'd0, auto: 1'b0, wait_n: 16'd20,  exp_count: 23'd0, exp_stat: 1'b1},
        '{load: 23'd3, div: 2'd0, auto: 1'b1, wait_n: 16'd9,   exp_count: 23'd2, exp_stat: 1'b1},
        '{load: 23'd2, div: 2'd1, auto: 1'b0, wait_n: 16'd40,  exp_count: 23'd0, exp_stat: 1'b0},
        '{load: 23'd2, div: 2'd1, auto: 1'b1, wait_n: 16'd48,  exp_count: 23'd2, exp_stat: 1'b1},
        '{load: 23'd1, div: 2'd2, auto: 1'b1, wait_n: 16'd600, exp_count: 23'd1, exp_stat: 1'b1},
        '{load: 23'd1, div: 2'd3, auto: 1'b0, wait_n: 16'd255, exp_count: 23'd1, exp_stat: 1'b0},
        '{load: 23'd1, div: 2'd3, auto: 1'b0, wait_n: 16'd512, exp_count: 23'd0, exp_stat: 1'b1},
        '{load: 23'd7, div: 2'd1, auto: 1'b1, wait_n: 16'd100, exp_count: 23'd1, exp_stat: 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        we = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_NS / 2) clk = ~clk;

    tmr_reload_timer u_tmr_reload_timer (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_sel_i   (sel),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // called just after a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic quiesce();
        wr(A_CTRL, 32'h0);
        wr(A_ACK, 32'h0);
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            report();
        end
    end

    initial begin
        logic [31:0] d, d2;
        int pulses;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_COUNT, d); check("R1 count", d, 32'h007F_FFFF);
        rd(A_CTRL, d);  check("R1 ctrl", d, 32'h0);
        rd(A_LOAD, d);  check("R1 load", d, 32'h0);
        @(negedge clk);
        rd(A_ALARM, d); check("R1 alarm", d, 32'h007F_FFFF);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // vector table: R4 ratios, R5 reload, R6 stop, R2 control readback
        for (int i = 0; i < NV; i++) begin
            quiesce();
            wr(A_LOAD, {9'b0, VECS[i].load});
            wr(A_CTRL, C_RUN | (VECS[i].auto ? C_AUTO : 32'h0) | {28'b0, VECS[i].div, 2'b0});
            repeat (int'(VECS[i].wait_n)) @(negedge clk);
            rd(A_COUNT, d);
            check("R4/R5 count", d, {9'b0, VECS[i].exp_count});
            rd(A_CTRL, d);
            check("R2/R6 ctrl", d, ({31'b0, VECS[i].exp_stat} << 8)
                                 | ((VECS[i].auto || !VECS[i].exp_stat) ? C_RUN : 32'h0)
                                 | (VECS[i].auto ? C_AUTO : 32'h0)
                                 | {28'b0, VECS[i].div, 2'b0});
        end

        // R2 count register and status bit ignore writes
        quiesce();
        rd(A_COUNT, d);
        @(negedge clk);
        wr(A_COUNT, 32'h0000_0123);
        rd(A_COUNT, d2); check("R2 count write ignored", d2, d);
        wr(A_CTRL, 32'h0000_0100);
        rd(A_CTRL, d); check("R2 status bit write ignored", d, 32'h0);
        check("R2 irq after status write", {31'b0, irq}, 32'h0);

        // R3 load while running
        quiesce();
        wr(A_LOAD, 32'd10);
        wr(A_CTRL, C_RUN);
        repeat (3) @(negedge clk);
        rd(A_COUNT, d); check("R3 before reload write", d, 32'd7);
        @(negedge clk);
        wr(A_LOAD, 32'd4);
        rd(A_COUNT, d); check("R3 load copied", d, 32'd4);
        @(negedge clk);
        rd(A_COUNT, d); check("R3 count after load", d, 32'd3);

        // R9 edge pulse
        quiesce();
        wr(A_LOAD, 32'd2);
        wr(A_CTRL, C_RUN);
        pulses = 0;
        for (int c = 1; c <= 8; c++) begin
            @(negedge clk);
            if (irq) pulses++;
            if (c == 3) check("R9 pulse at underflow edge", {31'b0, irq}, 32'h1);
        end
        check("R9 single pulse", pulses, 1);
        rd(A_CTRL, d); check("R8 status sticky", d & 32'h100, 32'h100);

        // R10 level output follows status
        wr(A_CTRL, C_LVL);
        check("R10 level high", {31'b0, irq}, 32'h1);
        wr(A_ACK, 32'h0);
        check("R10 level low after clear", {31'b0, irq}, 32'h0);

        // R8 event beats a clear in the same cycle
        quiesce();
        wr(A_LOAD, 32'd2);
        wr(A_CTRL, C_RUN | C_AUTO | C_LVL);
        repeat (5) @(negedge clk);
        wr(A_ACK, 32'h0);
        rd(A_CTRL, d); check("R8 event wins over clear", d & 32'h100, 32'h100);
        wr(A_ACK, 32'h0);
        rd(A_CTRL, d); check("R8 clear takes effect", d & 32'h100, 32'h0);

        // R7 alarm match
        quiesce();
        wr(A_ALARM, 32'd3);
        wr(A_LOAD, 32'd6);
        wr(A_CTRL, C_RUN);
        repeat (2) @(negedge clk);
        rd(A_CTRL, d); check("R7 no event before match", d & 32'h100, 32'h0);
        @(negedge clk);
        check("R7 alarm pulse", {31'b0, irq}, 32'h1);
        rd(A_COUNT, d); check("R7 count at match", d, 32'd3);
        rd(A_CTRL, d); check("R7 alarm status", d & 32'h100, 32'h100);

        // R7 alarm coinciding with underflow reload
        quiesce();
        wr(A_ALARM, 32'd2);
        wr(A_LOAD, 32'd2);
        wr(A_CTRL, C_RUN | C_AUTO);
        pulses = 0;
        for (int c = 1; c <= 5; c++) begin
            @(negedge clk);
            if (irq) pulses++;
            if (c == 3) check("R7 merged pulse edge", {31'b0, irq}, 32'h1);
        end
        check("R7 merged single pulse", pulses, 1);
        quiesce();
        wr(A_ALARM, 32'h007F_FFFF);

        finished = 1'b1;
        report();
    end
endmodule